// File: doc/BRIEF.md
# Nibble-Serial CRC-8 Generator

This block computes an 8-bit cyclic redundancy check over a stream of 4-bit data words, one word per clock. An 8-bit remainder register is advanced by a single-cycle combinational network that applies four polynomial bit-steps in one go. The generator polynomial is x^8+x^2+x+1 (0x07), data bits are taken most significant first, and the remainder starts at zero.

Three controls steer the register. A clear request empties it. A mode input chooses between computing, where each qualified data word is folded into the remainder, and draining, where each qualified cycle moves the remainder up by one nibble with zero fill. The 4-bit result port always shows the bitwise inverse of the upper nibble of the remainder, so after a frame the caller drops the mode input and reads the finished check value, upper nibble first, across two qualified cycles. With no qualifier and no clear, nothing moves.

Top module: `crc_nibble_gen`

## Requirements
- R1: While the active-low reset is asserted the remainder is 0x00, so crcOut reads 4'hF.
- R2: A cycle with initReq high loads 0x00 into the remainder whatever dataValid is; crcOut reads 4'hF after that edge.
- R3: With initReq low, calcMode high and dataValid high, the remainder becomes the CRC of the old remainder and dataIn, applying polynomial 0x07 to dataIn bits 3,2,1,0 in that order (per bit: feedback = rem[7] xor data bit; rem shifts left one with zero fill; if feedback is 1, xor 0x07).
- R4: With initReq low and dataValid low the remainder holds and crcOut is unchanged after the edge.
- R5: crcOut always equals the bitwise inverse of remainder bits [7:4].
- R6: With initReq low, calcMode low and dataValid high, the remainder shifts left by four with zeros entering bits [3:0]; after two such cycles crcOut reads 4'hF and stays so on further ones.
- R7: initReq takes priority over calcMode: with both high the remainder is cleared, not updated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| dataIn | input | 4 | Data nibble, bit 3 processed first |
| initReq | input | 1 | Clears the remainder to zero |
| calcMode | input | 1 | 1 = fold data into remainder, 0 = drain result |
| dataValid | input | 1 | Qualifies the current cycle for update or drain |
| crcOut | output | 4 | Inverse of remainder bits [7:4] |

## Verification
The assertions watch every cycle for the reset value, the all-ones output after a clear, the frozen output on unqualified cycles, and the all-ones output once two or more drain cycles have emptied the remainder. The arithmetic of the update network, the order of data bits and the exact nibbles that leave during draining are only shown by the bench, which runs random nibble streams with random gaps against a bit-serial reference and compares every cycle's output.

// File: rtl/crc_nibble_pkg.sv
package crc_nibble_pkg;

  // Next-value select for the remainder register.
  typedef enum logic [1:0] {
    SEL_HOLD   = 2'b00,
    SEL_CLEAR  = 2'b01,
    SEL_UPDATE = 2'b10,
    SEL_SHIFT  = 2'b11
  } remSel_e;

  // Strobes sent from control to datapath.
  typedef struct packed {
    remSel_e sel;
    logic    active;
  } ctrlStrobe_t;

endpackage

// File: rtl/crc_nibble_update.sv
// Unrolled CRC update: one polynomial step per data bit, MSB first.
module crc_nibble_update #(
  parameter int CRC_W  = 8,
  parameter int DATA_W = 4,
  parameter logic [CRC_W-1:0] POLY = 8'h07
) (
  input  logic [CRC_W-1:0]  remIn,
  input  logic [DATA_W-1:0] dataIn,
  output logic [CRC_W-1:0]  remOut
);

  logic [CRC_W-1:0] stage [DATA_W+1];

  assign stage[0] = remIn;

  for (genvar s = 0; s < DATA_W; s++) begin : g_step
    logic feedback;
    logic [CRC_W-1:0] shifted;
    assign feedback = stage[s][CRC_W-1] ^ dataIn[DATA_W-1-s];
    assign shifted  = {stage[s][CRC_W-2:0], 1'b0};
    assign stage[s+1] = feedback ? (shifted ^ POLY) : shifted;
  end

  assign remOut = stage[DATA_W];

endmodule

// File: rtl/crc_nibble_ctrl.sv
// Decodes the three controls into a remainder select; clear wins over mode.
module crc_nibble_ctrl
  import crc_nibble_pkg::*;
(
  input  logic        initReq,
  input  logic        calcMode,
  input  logic        dataValid,
  output ctrlStrobe_t strobe
);

  remSel_e selNext;

  always_comb begin
    if (initReq) begin
      selNext = SEL_CLEAR;
    end else if (!dataValid) begin
      selNext = SEL_HOLD;
    end else if (calcMode) begin
      selNext = SEL_UPDATE;
    end else begin
      selNext = SEL_SHIFT;
    end
  end

  assign strobe.sel    = selNext;
  assign strobe.active = (selNext != SEL_HOLD);

endmodule

// File: rtl/crc_nibble_dp.sv
// Remainder register with four-way next-value select and inverted readout.
module crc_nibble_dp
  import crc_nibble_pkg::*;
#(
  parameter int CRC_W  = 8,
  parameter int DATA_W = 4,
  parameter logic [CRC_W-1:0] POLY = 8'h07
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] crcOut
);

  localparam int KEEP_W = CRC_W - DATA_W;

  logic [CRC_W-1:0] remQ;
  logic [CRC_W-1:0] remUpd;
  logic [CRC_W-1:0] remShift;
  logic [CRC_W-1:0] remNext;

  crc_nibble_update #(
    .CRC_W (CRC_W),
    .DATA_W(DATA_W),
    .POLY  (POLY)
  ) u_update (
    .remIn (remQ),
    .dataIn(dataIn),
    .remOut(remUpd)
  );

  assign remShift = {remQ[KEEP_W-1:0], {DATA_W{1'b0}}};

  always_comb begin
    unique case (strobe.sel)
      SEL_CLEAR:  remNext = '0;
      SEL_UPDATE: remNext = remUpd;
      SEL_SHIFT:  remNext = remShift;
      default:    remNext = remQ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remQ <= '0;
    end else if (strobe.active) begin
      remQ <= remNext;
    end
  end

  assign crcOut = ~remQ[CRC_W-1 -: DATA_W];

endmodule

// File: rtl/crc_nibble_gen.sv
module crc_nibble_gen
  import crc_nibble_pkg::*;
#(
  parameter int CRC_W  = 8,
  parameter int DATA_W = 4,
  parameter logic [CRC_W-1:0] POLY = 8'h07
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              initReq,
  input  logic              calcMode,
  input  logic              dataValid,
  output logic [DATA_W-1:0] crcOut
);

  ctrlStrobe_t strobe;

  crc_nibble_ctrl u_ctrl (
    .initReq  (initReq),
    .calcMode (calcMode),
    .dataValid(dataValid),
    .strobe   (strobe)
  );

  crc_nibble_dp #(
    .CRC_W (CRC_W),
    .DATA_W(DATA_W),
    .POLY  (POLY)
  ) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .strobe(strobe),
    .dataIn(dataIn),
    .crcOut(crcOut)
  );

endmodule

// File: rtl/crc_nibble_gen_chk.sv
module crc_nibble_gen_chk #(
  parameter int CRC_W  = 8,
  parameter int DATA_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic [DATA_W-1:0] dataIn,
  input logic              initReq,
  input logic              calcMode,
  input logic              dataValid,
  input logic [DATA_W-1:0] crcOut
);

  localparam int EMPTY_AFTER = CRC_W / DATA_W;
  localparam int RUN_W = $clog2(EMPTY_AFTER + 1) + 1;

  logic [RUN_W-1:0] shiftRun;

  // Counts drain cycles since the last clear or update; saturates.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftRun <= '0;
    end else if (initReq || (calcMode && dataValid)) begin
      shiftRun <= '0;
    end else if (dataValid && shiftRun < RUN_W'(EMPTY_AFTER)) begin
      shiftRun <= shiftRun + 1'b1;
    end
  end

  AST_RESET_VALUE: assert property (@(posedge clk)
    !rstN |-> crcOut == {DATA_W{1'b1}}); // R1

  AST_CLEAR_ONES: assert property (@(posedge clk) disable iff (!rstN)
    initReq |=> crcOut == {DATA_W{1'b1}}); // R2

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!initReq && !dataValid) |=> $stable(crcOut)); // R4

  AST_DRAIN_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    (shiftRun >= RUN_W'(EMPTY_AFTER)) |-> crcOut == {DATA_W{1'b1}}); // R6

endmodule

bind crc_nibble_gen crc_nibble_gen_chk #(
  .CRC_W (CRC_W),
  .DATA_W(DATA_W)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .dataIn   (dataIn),
  .initReq  (initReq),
  .calcMode (calcMode),
  .dataValid(dataValid),
  .crcOut   (crcOut)
);

// File: tb/crc_nibble_gen_tb.sv
`timescale 1ns/1ps
module crc_nibble_gen_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] dataIn = '0;
  logic       initReq = 1'b0;
  logic       calcMode = 1'b0;
  logic       dataValid = 1'b0;
  logic [3:0] crcOut;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [3:0] expVal;
    string      tag;
  } expItem_t;

  expItem_t expQ[$];
  logic [7:0] modelRem = 8'h00;

  always #5 clk = ~clk;

  crc_nibble_gen u_dut (
    .clk      (clk),
    .rstN     (rstN),
    .dataIn   (dataIn),
    .initReq  (initReq),
    .calcMode (calcMode),
    .dataValid(dataValid),
    .crcOut   (crcOut)
  );

  // Bit-serial reference of R3.
  function automatic logic [7:0] refStep(logic [7:0] r, logic [3:0] d);
    for (int i = 3; i >= 0; i--) begin
      logic fb;
      fb = r[7] ^ d[i];
      r = {r[6:0], 1'b0};
      if (fb) r = r ^ 8'h07;
    end
    return r;
  endfunction

  task automatic check(string tag, logic [3:0] act, logic [3:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: crcOut=%h expected=%h", tag, act, exp);
    end
  endtask

  // Driver: apply one cycle, advance the model, queue the expected output.
  task automatic drive(logic i, logic c, logic v, logic [3:0] d, string tag);
    @(negedge clk);
    initReq = i; calcMode = c; dataValid = v; dataIn = d;
    @(posedge clk);
    if (i) modelRem = 8'h00;
    else if (v && c) modelRem = refStep(modelRem, d);
    else if (v) modelRem = {modelRem[3:0], 4'h0};
    expQ.push_back('{~modelRem[7:4], tag});
  endtask

  // Monitor: compare each queued expectation away from the clock edge.
  always @(negedge clk) begin
    if (expQ.size() > 0) begin
      expItem_t it;
      it = expQ.pop_front();
      check(it.tag, crcOut, it.expVal);
    end
  end

  task automatic runFrame(int len, bit gaps);
    drive(1'b1, 1'b1, 1'b0, 4'h0, "R2 clear before frame");
    for (int n = 0; n < len; n++) begin
      logic [3:0] d;
      d = 4'($urandom_range(0, 15));
      if (gaps && ($urandom_range(0, 3) == 0))
        drive(1'b0, 1'b1, 1'b0, 4'($urandom_range(0, 15)), "R4 hold on gap");
      drive(1'b0, 1'b1, 1'b1, d, "R3 update");
    end
    drive(1'b0, 1'b0, 1'b0, 4'h0, "R5 result upper nibble");
    drive(1'b0, 1'b0, 1'b1, 4'h0, "R6 first drain");
    drive(1'b0, 1'b0, 1'b1, 4'h5, "R6 second drain empty");
    drive(1'b0, 1'b0, 1'b1, 4'hA, "R6 stays empty");
  endtask

  initial begin
    // R1: reset value
    #12;
    check("R1 reset value", crcOut, 4'hF);
    @(negedge clk);
    rstN = 1'b1;

    // Directed: 0xF then 0x0 gives remainder from reference; check R5 early
    drive(1'b0, 1'b1, 1'b1, 4'hF, "R3 single nibble");
    drive(1'b0, 1'b1, 1'b1, 4'h0, "R3 second nibble");
    drive(1'b0, 1'b1, 1'b0, 4'h7, "R4 hold calc mode");
    drive(1'b0, 1'b0, 1'b0, 4'h7, "R4 hold drain mode");
    // R7: init with calc high and valid clears rather than updates
    drive(1'b1, 1'b1, 1'b1, 4'h9, "R7 clear beats calc");
    drive(1'b0, 1'b1, 1'b1, 4'h8, "R3 after clear");
    // R2: init with valid low still clears
    drive(1'b1, 1'b0, 1'b0, 4'h3, "R2 clear without valid");

    for (int f = 0; f < 40; f++) runFrame(1 + (f % 12), f[0]);
    for (int f = 0; f < 10; f++) runFrame(30, 1'b1);

    // Mid-frame drain then resume computing on the shifted remainder
    drive(1'b1, 1'b0, 1'b0, 4'h0, "R2 clear");
    drive(1'b0, 1'b1, 1'b1, 4'hC, "R3 update");
    drive(1'b0, 1'b1, 1'b1, 4'h3, "R3 update");
    drive(1'b0, 1'b0, 1'b1, 4'h0, "R6 partial drain");
    drive(1'b0, 1'b1, 1'b1, 4'h6, "R3 update after drain");

    @(negedge clk);
    @(negedge clk);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    #1000000;
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: run did not finish");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

endmodule